// File: doc/BRIEF.md
# Chained Descriptor DMA Channel Sequencer

This block is one DMA channel. It walks a linked list of command descriptors held in memory and carries each one out. Each descriptor starts with a fixed header. The header holds the address of the next descriptor, a control half-word and a byte count packed into one word, and a buffer address. Up to fifteen peripheral register words follow the header. The block reaches memory through a simple single-transaction bus master port. On the peripheral side it has a register-write strobe, a word stream toward the peripheral, a word stream from the peripheral, an end strobe and a terminate strobe.

Software first loads the address of the first descriptor. It then writes a nonzero value to the semaphore to start the channel. For each descriptor the sequencer writes the register words to the peripheral and then moves the data, if the command asks for it. Next it may wait for the peripheral end strobe. On completion it can raise an interrupt, decrement the semaphore and follow the chain. If the last descriptor points back to the first, the descriptors form a ring. A ring keeps running for as long as the semaphore stays above zero. A freeze input pauses the channel without losing its place, and a channel reset returns it to idle.

Top module: `dma_chain_seq`

## Requirements
- R1: After reset, or after a cycle with `chan_rst` high, `busy`, `irq`, `err_bus`, `err_term` and `sema_val` are all 0, and the next-command address is 0.
- R2: A semaphore write adds `sema_wdata` to `sema_val`. A write of a nonzero value while idle starts the channel at the loaded command address. A write of zero leaves the channel idle.
- R3: A descriptor at address A is read as follows. The next pointer is at A. The word at A+4 holds the control field in bits [15:0] and the byte count in bits [31:16]. The buffer address is at A+8. Register word k is at A+12+4k.
- R4: Control bits [15:12] give N, the number of register words. The N words are written to the peripheral with `pio_idx` running from 0 to N-1, all before any data movement. Command values 0 and 3 in control bits [1:0] move no data.
- R5: Command 2 (memory to peripheral) reads ceil(count/4) words from ascending buffer addresses and presents each one on `tx_data`. `tx_be` is 4'hF, except on the last word when count mod 4 = r is nonzero; that word gets the low r lanes, (1<<r)-1.
- R6: Command 1 (peripheral to memory) writes each received word to ascending buffer addresses, with `bus_be` following the same rule as R5. Memory bytes in disabled lanes keep their old value.
- R7: On completion, the descriptor's next pointer becomes the next-command address. If CHAIN (bit 2) is set and the semaphore is nonzero after any decrement, the next descriptor is fetched. Otherwise the channel goes idle, and a later nonzero semaphore write resumes it at that pointer.
- R8: A descriptor with DEC_SEM (bit 6) set decrements the semaphore on completion. A chained ring therefore runs exactly as many DEC_SEM descriptors as were written to the semaphore, then stops with `sema_val` = 0.
- R9: A completed descriptor with IRQ (bit 3) set gives exactly one single-cycle `irq` pulse.
- R10: A descriptor with WAIT4END (bit 7) set does not complete until `per_end` is seen after its data movement.
- R11: While `freeze` is high, no bus transaction, register write or stream word is started, and handshakes already under way are held. Clearing it resumes from the same place, with the same results as a run without the freeze.
- R12: `per_term` during a peripheral data phase stops the channel with no interrupt when HALT_ON_TERMINATE (bit 8) is set. If TERMINATE_FLUSH (bit 9) is also set, the held word is dropped and the sticky `err_term` is raised. Without bit 8, `per_term` has no effect.
- R13: A bus error response on any fetch or data access stops the channel and raises the sticky `err_bus`. `err_term` is not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_rst | input | 1 | Channel reset, returns to idle and clears state |
| freeze | input | 1 | Pause the channel in place |
| cmd_addr_wr | input | 1 | Load next-command address (honoured only while idle) |
| cmd_addr_wdata | input | AW | Address of the first descriptor |
| sema_wr | input | 1 | Semaphore write strobe |
| sema_wdata | input | SEMA_W | Value added to the semaphore |
| sema_val | output | SEMA_W | Current semaphore value |
| busy | output | 1 | Channel is not idle |
| irq | output | 1 | Completion pulse |
| err_bus | output | 1 | Sticky bus error flag |
| err_term | output | 1 | Sticky termination error flag |
| bus_req | output | 1 | Bus request, held until acknowledged |
| bus_we | output | 1 | Request is a write |
| bus_addr | output | AW | Byte address of the word |
| bus_wdata | output | 32 | Write data |
| bus_be | output | 4 | Write byte lanes |
| bus_ack | input | 1 | Transaction done |
| bus_err | input | 1 | Error response, valid with ack |
| bus_rdata | input | 32 | Read data, valid with ack |
| pio_wr | output | 1 | Peripheral register write strobe |
| pio_idx | output | 4 | Register word index |
| pio_data | output | 32 | Register word value |
| tx_valid | output | 1 | Word toward the peripheral is valid |
| tx_ready | input | 1 | Peripheral accepts the word |
| tx_data | output | 32 | Word toward the peripheral |
| tx_be | output | 4 | Valid byte lanes of that word |
| rx_valid | input | 1 | Peripheral offers a word |
| rx_ready | output | 1 | Channel accepts the word |
| rx_data | input | 32 | Word from the peripheral |
| per_end | input | 1 | Peripheral end-of-transfer strobe |
| per_term | input | 1 | Peripheral early-termination strobe |

## Verification
The handshake assertions take two things for granted. The bus answers each request with exactly one `bus_ack`, with `bus_err` qualifying that ack only. The peripheral treats `tx_valid`/`tx_ready` and `rx_valid`/`rx_ready` as valid-ready pairs. The bench memory model acks one cycle after each request and never acks without one. The stream models never withdraw a word they have offered. Every byte count the bench uses is far below the 0xFF00 limit. Semaphore writes made while the channel is running come early enough that the running count has not reached zero. `per_term` is held until the channel goes idle, so it is always seen in a peripheral data phase.

// File: rtl/dcs_pkg.sv
// Shared types for the descriptor channel sequencer.
// Assumes a 32-bit descriptor word; the control half-word layout is fixed.
package dcs_pkg;

    typedef enum logic [3:0] {
        S_IDLE, S_FNXT, S_FCTL, S_FBUF, S_PRD, S_PWR,
        S_MRD, S_TX, S_RX, S_MWR, S_WEND, S_DONE
    } dcs_state_e;

    localparam logic [1:0] CMD_TOMEM   = 2'd1;
    localparam logic [1:0] CMD_FROMMEM = 2'd2;

    typedef struct packed {
        logic [3:0] npio;
        logic       flush;
        logic       halt;
        logic       wend;
        logic       dsem;
        logic       irq;
        logic       chain;
        logic [1:0] cmd;
    } dcs_ctl_t;

    // Unpack the control half-word into its fields.
    function automatic dcs_ctl_t dcs_decode(input logic [15:0] w);
        dcs_ctl_t c;
        c.cmd   = w[1:0];
        c.chain = w[2];
        c.irq   = w[3];
        c.dsem  = w[6];
        c.wend  = w[7];
        c.halt  = w[8];
        c.flush = w[9];
        c.npio  = w[15:12];
        return c;
    endfunction

endpackage

// File: rtl/dcs_sema.sv
// Channel semaphore: adds written values (saturating), decrements by one
// on request when nonzero. Assumes clr has priority over everything.
module dcs_sema #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    input  logic [W-1:0] inc_val,
    input  logic         dec,
    output logic [W-1:0] cnt
);
    localparam logic [W:0] MAXV = {1'b0, {W{1'b1}}};

    logic [W:0] sum;

    // Next value: add, then take one away, then clamp.
    always_comb begin
        sum = {1'b0, cnt} + (inc ? {1'b0, inc_val} : '0)
              - ((dec && cnt != '0) ? {{W{1'b0}}, 1'b1} : '0);
        if (sum > MAXV) sum = MAXV;
    end

    // Counter register.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else               cnt <= sum[W-1:0];
    end

    p_sema_dec_r8: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (dec && !inc && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/dcs_lanes.sv
// Word count and byte-lane mask for a byte count moved in whole words.
// Assumes word_idx stays below the word count while it is used.
module dcs_lanes #(
    parameter int CW  = 16,
    parameter int BEW = 4
) (
    input  logic [CW-1:0]  cnt,
    input  logic [CW-1:0]  word_idx,
    output logic           is_last,
    output logic [BEW-1:0] be
);
    localparam int LB = $clog2(BEW);

    logic [CW:0]   words;
    logic [LB-1:0] rem;

    assign words   = ({1'b0, cnt} + (CW+1)'(BEW - 1)) >> LB;
    assign rem     = cnt[LB-1:0];
    assign is_last = ({1'b0, word_idx} == words - 1'b1);

    // One enable per lane; only the last partial word trims lanes.
    for (genvar l = 0; l < BEW; l++) begin : g_lane
        assign be[l] = !is_last || (rem == '0) || (32'(rem) > l);
    end

endmodule

// File: rtl/dcs_hold.sv
// Keeps a request asserted once offered: freeze may stop a request from
// starting but never withdraws one the partner has already seen.
// Assumes 'want' stays high until 'done' or 'abort'.
module dcs_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic want,
    input  logic freeze,
    input  logic done,
    input  logic abort,
    output logic out
);
    logic live;

    assign out = want && (live || !freeze);

    // Remember that a request was offered and not yet taken.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)               live <= 1'b0;
        else if (abort || done || !want) live <= 1'b0;
        else if (out)                    live <= 1'b1;
    end

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (out && !done && !abort) |=> out);

endmodule

// File: rtl/dma_chain_seq.sv
// One DMA channel that executes a linked list of command descriptors.
// Assumes one outstanding bus transaction, ack with optional error, and
// valid-ready streams on the peripheral side. AW must not exceed 32.
module dma_chain_seq
    import dcs_pkg::*;
#(
    parameter int AW     = 32,
    parameter int SEMA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chan_rst,
    input  logic              freeze,
    input  logic              cmd_addr_wr,
    input  logic [AW-1:0]     cmd_addr_wdata,
    input  logic              sema_wr,
    input  logic [SEMA_W-1:0] sema_wdata,
    output logic [SEMA_W-1:0] sema_val,
    output logic              busy,
    output logic              irq,
    output logic              err_bus,
    output logic              err_term,
    output logic              bus_req,
    output logic              bus_we,
    output logic [AW-1:0]     bus_addr,
    output logic [31:0]       bus_wdata,
    output logic [3:0]        bus_be,
    input  logic              bus_ack,
    input  logic              bus_err,
    input  logic [31:0]       bus_rdata,
    output logic              pio_wr,
    output logic [3:0]        pio_idx,
    output logic [31:0]       pio_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [31:0]       tx_data,
    output logic [3:0]        tx_be,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic [31:0]       rx_data,
    input  logic              per_end,
    input  logic              per_term
);
    localparam int DW  = 32;
    localparam int BEW = DW / 8;
    localparam int CW  = 16;

    dcs_state_e      st;
    dcs_ctl_t        ctl;
    logic [AW-1:0]   cur_addr, desc_addr, nxt_ptr, bufa;
    logic [CW-1:0]   cnt, widx;
    logic [3:0]      pio_k;
    logic [DW-1:0]   hold_word;
    logic            bus_want, ack_ok, ack_bad, term_hit, done_fire;
    logic            is_last, dec_now, go_on, start;
    logic [BEW-1:0]  lane_be;
    dcs_state_e      data_st, post_st;

    dcs_lanes #(.CW(CW), .BEW(BEW)) u_lanes (
        .cnt(cnt), .word_idx(widx), .is_last(is_last), .be(lane_be)
    );

    dcs_sema #(.W(SEMA_W)) u_sema (
        .clk(clk), .rst_n(rst_n), .clr(chan_rst), .inc(sema_wr),
        .inc_val(sema_wdata), .dec(done_fire && ctl.dsem), .cnt(sema_val)
    );

    dcs_hold u_bus_hold (
        .clk(clk), .rst_n(rst_n), .clr(chan_rst), .want(bus_want),
        .freeze(freeze), .done(bus_ack), .abort(1'b0), .out(bus_req)
    );

    dcs_hold u_tx_hold (
        .clk(clk), .rst_n(rst_n), .clr(chan_rst), .want(st == S_TX),
        .freeze(freeze), .done(tx_ready), .abort(term_hit), .out(tx_valid)
    );

    // Bus request decode per state.
    always_comb begin
        bus_want = 1'b1;
        bus_we   = 1'b0;
        bus_be   = '1;
        case (st)
            S_FNXT:  bus_addr = desc_addr;
            S_FCTL:  bus_addr = desc_addr + AW'(4);
            S_FBUF:  bus_addr = desc_addr + AW'(8);
            S_PRD:   bus_addr = desc_addr + AW'(12) + AW'({pio_k, 2'b00});
            S_MRD:   bus_addr = bufa + AW'({widx, 2'b00});
            S_MWR: begin
                bus_addr = bufa + AW'({widx, 2'b00});
                bus_we   = 1'b1;
                bus_be   = lane_be;
            end
            default: begin
                bus_addr = '0;
                bus_want = 1'b0;
            end
        endcase
    end

    // Step conditions shared by the state machine.
    always_comb begin
        ack_ok    = bus_req && bus_ack && !bus_err;
        ack_bad   = bus_req && bus_ack && bus_err;
        term_hit  = per_term && ctl.halt && (st == S_TX || st == S_RX);
        done_fire = (st == S_DONE) && !freeze;
        dec_now   = ctl.dsem && (sema_val != '0);
        go_on     = ctl.chain && ((sema_val - SEMA_W'(dec_now)) != '0);
        start     = sema_wr && (sema_wdata != '0);
        post_st   = ctl.wend ? S_WEND : S_DONE;
        if (ctl.cmd == CMD_FROMMEM && cnt != '0)    data_st = S_MRD;
        else if (ctl.cmd == CMD_TOMEM && cnt != '0) data_st = S_RX;
        else                                        data_st = post_st;
    end

    assign busy      = (st != S_IDLE);
    assign irq       = done_fire && ctl.irq;
    assign pio_wr    = (st == S_PWR) && !freeze;
    assign pio_idx   = pio_k;
    assign pio_data  = hold_word;
    assign tx_data   = hold_word;
    assign tx_be     = lane_be;
    assign bus_wdata = hold_word;
    assign rx_ready  = (st == S_RX) && !freeze;

    // Descriptor sequencing state machine.
    always_ff @(posedge clk) begin
        if (!rst_n || chan_rst) begin
            st        <= S_IDLE;
            cur_addr  <= '0;
            desc_addr <= '0;
            nxt_ptr   <= '0;
            bufa      <= '0;
            ctl       <= '0;
            cnt       <= '0;
            widx      <= '0;
            pio_k     <= '0;
            hold_word <= '0;
            err_bus   <= 1'b0;
            err_term  <= 1'b0;
        end else if (ack_bad) begin
            err_bus <= 1'b1;
            st      <= S_IDLE;
        end else if (term_hit) begin
            if (ctl.flush) err_term <= 1'b1;
            st <= S_IDLE;
        end else begin
            case (st)
                S_IDLE: begin
                    if (cmd_addr_wr) cur_addr <= cmd_addr_wdata;
                    if (start) begin
                        desc_addr <= cmd_addr_wr ? cmd_addr_wdata : cur_addr;
                        st        <= S_FNXT;
                    end
                end
                S_FNXT: if (ack_ok) begin
                    nxt_ptr <= bus_rdata[AW-1:0];
                    st      <= S_FCTL;
                end
                S_FCTL: if (ack_ok) begin
                    ctl <= dcs_decode(bus_rdata[15:0]);
                    cnt <= bus_rdata[31:16];
                    st  <= S_FBUF;
                end
                S_FBUF: if (ack_ok) begin
                    bufa  <= bus_rdata[AW-1:0];
                    pio_k <= '0;
                    widx  <= '0;
                    st    <= (ctl.npio != '0) ? S_PRD : data_st;
                end
                S_PRD: if (ack_ok) begin
                    hold_word <= bus_rdata;
                    st        <= S_PWR;
                end
                S_PWR: if (!freeze) begin
                    if (pio_k == ctl.npio - 1'b1) st <= data_st;
                    else begin
                        pio_k <= pio_k + 1'b1;
                        st    <= S_PRD;
                    end
                end
                S_MRD: if (ack_ok) begin
                    hold_word <= bus_rdata;
                    st        <= S_TX;
                end
                S_TX: if (tx_valid && tx_ready) begin
                    if (is_last) st <= post_st;
                    else begin
                        widx <= widx + 1'b1;
                        st   <= S_MRD;
                    end
                end
                S_RX: if (rx_valid && rx_ready) begin
                    hold_word <= rx_data;
                    st        <= S_MWR;
                end
                S_MWR: if (ack_ok) begin
                    if (is_last) st <= post_st;
                    else begin
                        widx <= widx + 1'b1;
                        st   <= S_RX;
                    end
                end
                S_WEND: if (per_end || (per_term && ctl.halt)) st <= S_DONE;
                S_DONE: if (!freeze) begin
                    cur_addr <= nxt_ptr;
                    if (go_on) begin
                        desc_addr <= nxt_ptr;
                        st        <= S_FNXT;
                    end else begin
                        st <= S_IDLE;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    p_idle_start_r2: assert property (@(posedge clk) disable iff (!rst_n || chan_rst)
        (!busy && !(sema_wr && sema_wdata != '0)) |=> !busy);

    p_irq_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n || chan_rst)
        irq |=> !irq);

    p_lane_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n || chan_rst)
        (bus_req && bus_we) |-> (bus_be != '0));

    p_freeze_r11: assert property (@(posedge clk) disable iff (!rst_n || chan_rst)
        (freeze && !bus_req) |=> (!bus_req || !freeze));

    p_bus_sticky_r13: assert property (@(posedge clk) disable iff (!rst_n || chan_rst)
        err_bus |=> err_bus);

endmodule

// File: tb/dma_chain_seq_test.sv
`timescale 1ns/100ps
module dma_chain_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chan_rst = 1'b0, freeze = 1'b0;
    logic        cmd_addr_wr = 1'b0, sema_wr = 1'b0;
    logic [31:0] cmd_addr_wdata = '0;
    logic [7:0]  sema_wdata = '0;
    logic [7:0]  sema_val;
    logic        busy, irq, err_bus, err_term;
    logic        bus_req, bus_we, bus_ack, bus_err;
    logic [31:0] bus_addr, bus_wdata, bus_rdata;
    logic [3:0]  bus_be, pio_idx, tx_be;
    logic        pio_wr, tx_valid, tx_ready, rx_valid, rx_ready;
    logic [31:0] pio_data, tx_data, rx_data;
    logic        per_end = 1'b0, per_term = 1'b0;

    always #2.5 clk = ~clk;

    dma_chain_seq uut (
        .clk(clk), .rst_n(rst_n), .chan_rst(chan_rst), .freeze(freeze),
        .cmd_addr_wr(cmd_addr_wr), .cmd_addr_wdata(cmd_addr_wdata),
        .sema_wr(sema_wr), .sema_wdata(sema_wdata), .sema_val(sema_val),
        .busy(busy), .irq(irq), .err_bus(err_bus), .err_term(err_term),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_ack(bus_ack),
        .bus_err(bus_err), .bus_rdata(bus_rdata), .pio_wr(pio_wr),
        .pio_idx(pio_idx), .pio_data(pio_data), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .tx_data(tx_data), .tx_be(tx_be),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
        .per_end(per_end), .per_term(per_term)
    );

    int vectors = 0, fails = 0;
    logic [31:0] mem [0:1023];
    logic [31:0] err_addr = 32'hFFFF_FFFF;
    int cyc = 0;
    logic mon_clr = 1'b0, tx_slow = 1'b0;
    int pio_n, tx_n, rx_k, irq_n, first_tx, last_pio;
    logic [31:0] pio_d [0:31];
    logic [3:0]  pio_i [0:31];
    logic [31:0] tx_d [0:31];
    logic [3:0]  tx_b [0:31];

    assign rx_valid = 1'b1;
    assign rx_data  = 32'hC0DE_0000 + rx_k;
    assign tx_ready = tx_slow ? cyc[0] : 1'b1;

    // Memory slave: acks one cycle after each request.
    always @(posedge clk) begin
        if (!rst_n) begin
            bus_ack <= 1'b0; bus_err <= 1'b0; bus_rdata <= '0;
        end else begin
            bus_ack <= 1'b0;
            bus_err <= 1'b0;
            if (bus_req && !bus_ack) begin
                bus_ack <= 1'b1;
                if (bus_addr == err_addr) bus_err <= 1'b1;
                else if (bus_we) begin
                    for (int l = 0; l < 4; l++)
                        if (bus_be[l]) mem[bus_addr[11:2]][8*l +: 8] = bus_wdata[8*l +: 8];
                end else bus_rdata <= mem[bus_addr[11:2]];
            end
        end
    end

    // Peripheral and interrupt monitors.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mon_clr) begin
            pio_n <= 0; tx_n <= 0; rx_k <= 0; irq_n <= 0; first_tx <= 0; last_pio <= 0;
        end else begin
            if (pio_wr) begin
                pio_d[pio_n & 31] <= pio_data; pio_i[pio_n & 31] <= pio_idx;
                pio_n <= pio_n + 1; last_pio <= cyc;
            end
            if (tx_valid && tx_ready) begin
                tx_d[tx_n & 31] <= tx_data; tx_b[tx_n & 31] <= tx_be;
                if (tx_n == 0) first_tx <= cyc;
                tx_n <= tx_n + 1;
            end
            if (rx_valid && rx_ready) rx_k <= rx_k + 1;
            if (irq) irq_n <= irq_n + 1;
        end
    end

    // Watchdog.
    always @(posedge clk) if (cyc > 150000) begin
        fails = fails + 1;
        $display("FAIL R1 watchdog expired actual=%0d expected<150000", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors = vectors + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] mk_ctl(input int cmd, input bit chain, input bit irqb,
        input bit dsem, input bit wend, input bit halt, input bit flush, input int npio);
        return 16'(cmd & 3) | (16'(chain) << 2) | (16'(irqb) << 3) | (16'(dsem) << 6)
             | (16'(wend) << 7) | (16'(halt) << 8) | (16'(flush) << 9) | 16'((npio & 15) << 12);
    endfunction

    function automatic logic [31:0] pio_word(input int a, input int k);
        return 32'h5000_0000 | 32'(a << 8) | 32'(k);
    endfunction

    function automatic logic [3:0] exp_be(input int c, input int i);
        if (i == (c + 3) / 4 - 1 && (c % 4) != 0) return 4'((1 << (c % 4)) - 1);
        return 4'hF;
    endfunction

    task automatic put_desc(input int a, input int nxt, input logic [15:0] ctl,
                            input int cnt, input int bufa);
        mem[a/4]     = 32'(nxt);
        mem[a/4 + 1] = {16'(cnt), ctl};
        mem[a/4 + 2] = 32'(bufa);
        for (int k = 0; k < 15; k++) mem[a/4 + 3 + k] = pio_word(a, k);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic fresh();
        @(negedge clk); chan_rst = 1'b1; mon_clr = 1'b1;
        @(negedge clk); chan_rst = 1'b0; mon_clr = 1'b0;
    endtask

    task automatic sema_write(input int v);
        @(negedge clk); sema_wr = 1'b1; sema_wdata = 8'(v);
        @(negedge clk); sema_wr = 1'b0;
    endtask

    task automatic kick(input int a, input int v);
        @(negedge clk); cmd_addr_wr = 1'b1; cmd_addr_wdata = 32'(a);
        @(negedge clk); cmd_addr_wr = 1'b0;
        sema_write(v);
    endtask

    task automatic wait_idle();
        int n = 0;
        tick(3);
        while (busy && n < 5000) begin @(negedge clk); n++; end
    endtask

    int snap;
    logic [31:0] expw;

    initial begin
        for (int w = 0; w < 1024; w++) mem[w] = 32'hB000_0000 + 32'(w);
        mon_clr = 1'b1;
        tick(4);
        rst_n = 1'b1;
        tick(1);
        mon_clr = 1'b0;
        tick(1);
        // R1 reset state
        chk("R1 busy", busy, 0); chk("R1 irq", irq, 0); chk("R1 sema", sema_val, 0);
        chk("R1 err_bus", err_bus, 0); chk("R1 err_term", err_term, 0);

        // R3/R4 register-word sweep, command 0
        for (int n = 0; n < 16; n++) begin
            fresh();
            put_desc(32'h40, 0, mk_ctl(0, 0, 1, 1, 0, 0, 0, n), 8, 32'h800);
            kick(32'h40, 1);
            wait_idle();
            chk("R4 pio count", pio_n, n);
            chk("R4 no data cmd0", tx_n, 0);
            for (int k = 0; k < n; k++) begin
                chk("R3 pio word", pio_d[k], pio_word(32'h40, k));
                chk("R4 pio index", 32'(pio_i[k]), k);
            end
            chk("R9 irq once", irq_n, 1);
            chk("R8 sema dec", sema_val, 0);
        end

        // R4 command 3 moves no data
        fresh();
        put_desc(32'h40, 0, mk_ctl(3, 0, 1, 1, 0, 0, 0, 1), 8, 32'h800);
        kick(32'h40, 1);
        wait_idle();
        chk("R4 cmd3 no tx", tx_n, 0);
        chk("R4 cmd3 pio", pio_n, 1);

        // R5 memory to peripheral sweep
        for (int c = 0; c < 10; c++) begin
            fresh();
            tx_slow = c[0];
            put_desc(32'h0, 0, mk_ctl(2, 0, 1, 1, 0, 0, 0, 2), c, 32'h800);
            kick(0, 1);
            wait_idle();
            chk("R5 word count", tx_n, (c + 3) / 4);
            for (int i = 0; i < (c + 3) / 4; i++) begin
                chk("R5 tx data", tx_d[i], mem[32'h200 + i]);
                chk("R5 tx lanes", 32'(tx_b[i]), 32'(exp_be(c, i)));
            end
            if (c > 0) chk("R4 pio before data", 32'(last_pio < first_tx), 1);
        end
        tx_slow = 1'b0;

        // R6 peripheral to memory sweep
        for (int c = 0; c < 10; c++) begin
            fresh();
            for (int i = 0; i < 4; i++) mem[32'h240 + i] = 32'hEEEE_0000 + 32'(i);
            put_desc(32'h0, 0, mk_ctl(1, 0, 1, 1, 0, 0, 0, 0), c, 32'h900);
            kick(0, 1);
            wait_idle();
            for (int i = 0; i < 4; i++) begin
                expw = 32'hEEEE_0000 + 32'(i);
                if (i < (c + 3) / 4)
                    for (int l = 0; l < 4; l++)
                        if (exp_be(c, i) & (4'd1 << l))
                            expw[8*l +: 8] = 8'((32'hC0DE_0000 + 32'(i)) >> (8*l));
                chk("R6 mem word", mem[32'h240 + i], expw);
            end
        end

        // R7 chain of three, then resume at the last next pointer
        fresh();
        put_desc(32'h000, 32'h080, mk_ctl(2, 1, 1, 0, 0, 0, 0, 0), 4, 32'h800);
        put_desc(32'h080, 32'h100, mk_ctl(2, 1, 1, 0, 0, 0, 0, 0), 4, 32'h840);
        put_desc(32'h100, 32'h180, mk_ctl(2, 0, 1, 1, 0, 0, 0, 0), 4, 32'h880);
        put_desc(32'h180, 32'h000, mk_ctl(0, 0, 1, 1, 0, 0, 0, 1), 0, 32'h800);
        kick(0, 1);
        wait_idle();
        chk("R7 chain irqs", irq_n, 3);
        chk("R7 chain tx0", tx_d[0], mem[32'h200]);
        chk("R7 chain tx1", tx_d[1], mem[32'h210]);
        chk("R7 chain tx2", tx_d[2], mem[32'h220]);
        chk("R7 no pio yet", pio_n, 0);
        sema_write(1);
        wait_idle();
        chk("R7 resume pio", pio_n, 1);
        chk("R7 resume word", pio_d[0], pio_word(32'h180, 0));

        // R8 ring limited by semaphore; R2 writes add
        fresh();
        put_desc(32'h000, 32'h080, mk_ctl(0, 1, 1, 1, 0, 0, 0, 1), 0, 32'h800);
        put_desc(32'h080, 32'h000, mk_ctl(0, 1, 1, 1, 0, 0, 0, 1), 0, 32'h800);
        kick(0, 2);
        sema_write(3);
        wait_idle();
        chk("R8 ring count", pio_n, 5);
        chk("R9 ring irqs", irq_n, 5);
        chk("R8 sema zero", sema_val, 0);
        chk("R8 ring order", pio_d[4], pio_word(0, 0));
        chk("R8 ring order b", pio_d[3], pio_word(32'h80, 0));

        // R2 zero write does not start
        fresh();
        kick(0, 0);
        tick(10);
        chk("R2 zero no start", busy, 0);
        chk("R2 zero no pio", pio_n, 0);

        // R10 wait for end strobe
        fresh();
        put_desc(32'h0, 0, mk_ctl(0, 0, 1, 1, 1, 0, 0, 0), 0, 32'h800);
        kick(0, 1);
        tick(20);
        chk("R10 still busy", busy, 1);
        chk("R10 no irq yet", irq_n, 0);
        per_end = 1'b1; tick(1); per_end = 1'b0;
        wait_idle();
        chk("R10 done", busy, 0);
        chk("R10 irq", irq_n, 1);

        // R11 freeze mid-list
        fresh();
        put_desc(32'h0, 0, mk_ctl(2, 0, 1, 1, 0, 0, 0, 0), 16, 32'h800);
        kick(0, 1);
        while (tx_n < 1) @(negedge clk);
        freeze = 1'b1;
        tick(1);
        snap = tx_n;
        tick(30);
        chk("R11 frozen tx", tx_n, snap);
        chk("R11 frozen busy", busy, 1);
        freeze = 1'b0;
        wait_idle();
        chk("R11 resume count", tx_n, 4);
        for (int i = 0; i < 4; i++) chk("R11 resume data", tx_d[i], mem[32'h200 + i]);
        chk("R11 resume irq", irq_n, 1);

        // R12 terminate with halt and flush
        fresh();
        tx_slow = 1'b1;
        put_desc(32'h0, 0, mk_ctl(2, 0, 1, 1, 0, 1, 1, 0), 32, 32'h800);
        kick(0, 1);
        while (tx_n < 2) @(negedge clk);
        per_term = 1'b1;
        wait_idle();
        per_term = 1'b0;
        chk("R12 halted", busy, 0);
        chk("R12 err_term", err_term, 1);
        chk("R12 no irq", irq_n, 0);
        chk("R12 short", 32'(tx_n < 8), 1);
        chk("R12 not bus err", err_bus, 0);
        fresh();
        chk("R1 chan_rst clears err_term", err_term, 0);
        // halt without flush
        put_desc(32'h0, 0, mk_ctl(2, 0, 1, 1, 0, 1, 0, 0), 32, 32'h800);
        kick(0, 1);
        while (tx_n < 2) @(negedge clk);
        per_term = 1'b1;
        wait_idle();
        per_term = 1'b0;
        chk("R12 halt no flush idle", busy, 0);
        chk("R12 halt no flush flag", err_term, 0);
        // no halt: terminate ignored
        fresh();
        put_desc(32'h0, 0, mk_ctl(2, 0, 1, 1, 0, 0, 1, 0), 32, 32'h800);
        kick(0, 1);
        per_term = 1'b1;
        wait_idle();
        per_term = 1'b0;
        chk("R12 ignored count", tx_n, 8);
        chk("R12 ignored irq", irq_n, 1);
        chk("R12 ignored flag", err_term, 0);
        tx_slow = 1'b0;

        // R13 bus error on a data read
        fresh();
        err_addr = 32'h804;
        put_desc(32'h0, 0, mk_ctl(2, 0, 1, 1, 0, 0, 0, 0), 16, 32'h800);
        kick(0, 1);
        wait_idle();
        err_addr = 32'hFFFF_FFFF;
        chk("R13 stopped", busy, 0);
        chk("R13 err_bus", err_bus, 1);
        chk("R13 one word", tx_n, 1);
        chk("R13 no term flag", err_term, 0);
        chk("R13 no irq", irq_n, 0);
        fresh();
        chk("R1 chan_rst err_bus", err_bus, 0);
        chk("R1 chan_rst sema", sema_val, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule